// File: doc/BRIEF.md
# CAN Bit Timing Sample Generator

This block divides the module clock into time quanta and walks each CAN bit through a sync quantum, a first timing segment and a second timing segment. At the end of the first segment it fires a one-clock sample strobe together with the sampled bus value. The received bit is either one line sample or, in triple-sample mode, the 2-of-3 majority of three samples.

The block follows the receive line. A recessive-to-dominant edge while the bus is idle restarts the bit (hard synchronisation). An edge inside a bit moves the sample point by at most the synchronisation jump width (soft resynchronisation). Rising edges are never used.

All timing settings come from one packed 32-bit configuration word. The word can only be loaded after a change request has been raised and acknowledged. While the request or its acknowledge is high, bit timing is parked. Dropping the request starts bit timing again with the new settings.

Top module: `can_bit_timing`

## Requirements
- R1: `cfg_ack` is 0 after reset and, in every later clock, equals the value `cfg_req` had one clock earlier.
- R2: A configuration write is stored only in a clock where `cfg_wr`, `cfg_req` and `cfg_ack` are all 1. Any other write leaves the bit timing unchanged.
- R3: While `cfg_ack` is 1, neither `tq_tick` nor `sample_stb` is asserted.
- R4: The word field at bits 23:16 holds the prescaler minus one (BRP = field + 1, range 1 to 256). `tq_tick` pulses for one clock every BRP clocks.
- R5: The bit time is (1 + TSEG1 + TSEG2) quanta, so `sample_stb` repeats every BRP × (1 + TSEG1 + TSEG2) clocks. TSEG1 = bits 6:3 + 1 (range 1 to 16) and TSEG2 = bits 2:0 + 1 (range 1 to 8).
- R6: A falling edge on `rx_in` sampled with `bus_idle` = 1 restarts the bit with its sync quantum. The next `sample_stb` is high during the clock that begins BRP × (1 + TSEG1) rising edges after the edge was seen.
- R7: A falling edge seen in quantum e (counted from 1) of TSEG1 lengthens TSEG1 by min(e, SJW). SJW = bits 9:8 + 1.
- R8: A falling edge seen in TSEG2 with r quanta left shortens TSEG2 by min(r, SJW). If r ≤ SJW, the sync quantum of the next bit starts at that edge.
- R9: At most one soft resynchronisation happens per bit. A second falling edge in the same bit has no effect.
- R10: If bit 7 is set and BRP > 4, `sample_bit` is the majority of the line value at the sample-point quantum tick and at the two quantum ticks before it.
- R11: If bit 7 is clear, or BRP ≤ 4, `sample_bit` is the line value at the sample-point quantum tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Change-configuration request |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Packed configuration word |
| cfg_ack | output | 1 | Change-enable status; writes are accepted while high |
| rx_in | input | 1 | Synchronised receive line (1 = recessive) |
| bus_idle | input | 1 | Bus idle indication from the frame logic |
| tq_tick | output | 1 | One-clock pulse at the end of each time quantum |
| sample_stb | output | 1 | One-clock pulse when a bit has been sampled |
| sample_bit | output | 1 | Sampled bit value, valid with `sample_stb` |

## Verification
The delicate collision is a falling edge detected in the same clock as a quantum tick. The segment logic must fold the phase correction and the quantum step into one update. With a prescaler of 1, every clock is a tick, so each soft-resynchronisation scenario forces this overlap. That includes an edge in the last quantum of the second segment, where the correction and the end of the bit coincide. Each case is judged by counting rising edges from the hard-sync edge to the following strobe and comparing the count with the segment arithmetic of R7 to R9.

// File: rtl/can_bt_pkg.sv
// Package: shared field layout and types of the bit timing generator.
// Assumes a 32-bit configuration word with minus-one encoded fields.
package can_bt_pkg;

    localparam int WORD_W     = 32;
    localparam int BRP_W      = 8;
    localparam int TSEG1_W    = 4;
    localparam int TSEG2_W    = 3;
    localparam int SJW_W      = 2;
    localparam int TSEG1_MAX  = 1 << TSEG1_W;
    localparam int SJW_MAX    = 1 << SJW_W;
    localparam int REM_W      = $clog2(TSEG1_MAX + SJW_MAX + 1);
    localparam int TRIPLE_MIN_BRP_M1 = 4;   // triple sampling needs BRP > 4

    typedef struct packed {
        logic [BRP_W-1:0]   brp_m1;
        logic [SJW_W-1:0]   sjw_m1;
        logic               triple;
        logic [TSEG1_W-1:0] tseg1_m1;
        logic [TSEG2_W-1:0] tseg2_m1;
    } bt_cfg_t;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_SEG1 = 2'd1,
        PH_SEG2 = 2'd2
    } bt_phase_e;

    // Extract the timing fields from the packed configuration word.
    function automatic bt_cfg_t unpack_word(input logic [WORD_W-1:0] w);
        bt_cfg_t c;
        c.tseg2_m1 = w[2:0];
        c.tseg1_m1 = w[6:3];
        c.triple   = w[7];
        c.sjw_m1   = w[9:8];
        c.brp_m1   = w[23:16];
        return c;
    endfunction

endpackage

// File: rtl/can_bt_cfg.sv
// Configuration holder: acknowledges change requests one clock late and
// accepts a new word only while request and acknowledge are both high.
module can_bt_cfg
    import can_bt_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    output bt_cfg_t           cfg_q
);

    logic unused_bits;
    assign unused_bits = ^{cfg_wdata[31:24], cfg_wdata[15:10]};

    // Track the request with a one-clock acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_ack <= 1'b0;
        else        cfg_ack <= cfg_req;
    end

    // Load the word only inside an acknowledged change window.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cfg_q <= unpack_word(RESET_WORD);
        else if (cfg_wr && cfg_req && cfg_ack) cfg_q <= unpack_word(cfg_wdata);
    end

endmodule

// File: rtl/can_bt_prescaler.sv
// Quantum prescaler: emits one tick every (brp_m1 + 1) clocks.
// Assumes hold parks the counter and restart realigns it to a new quantum.
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp_m1,
    output logic             tick
);

    logic [BRP_W-1:0] cnt_q;

    assign tick = !hold && (cnt_q == brp_m1);

    // Count clocks within the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || restart) cnt_q <= '0;
        else if (cnt_q == brp_m1)      cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/can_bt_segment.sv
// Segment sequencer: walks sync, first and second segment quanta, flags the
// sample point and applies hard and soft resynchronisation on falling edges.
// Assumes rx_in is already synchronised to clk; one soft resync per bit.
module can_bt_segment
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  logic    tick,
    input  logic    rx_in,
    input  logic    bus_idle,
    input  bt_cfg_t cfg,
    output logic    restart,
    output logic    sample_point
);

    bt_phase_e        ph_q, ph_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic             done_q, done_d;
    logic             rx_q;
    logic             fall;
    logic [REM_W-1:0] tseg1, tseg2, sjw, err1, step, adj;

    assign fall  = rx_q && !rx_in;
    assign tseg1 = REM_W'(cfg.tseg1_m1) + 1'b1;
    assign tseg2 = REM_W'(cfg.tseg2_m1) + 1'b1;
    assign sjw   = REM_W'(cfg.sjw_m1) + 1'b1;
    assign err1  = tseg1 - rem_q + 1'b1;

    // Next-state: phase step on a tick, merged with any phase correction.
    always_comb begin
        ph_d         = ph_q;
        rem_d        = rem_q;
        done_d       = done_q;
        restart      = 1'b0;
        sample_point = 1'b0;
        step         = '0;
        adj          = rem_q;
        if (hold) begin
            ph_d   = PH_SYNC;
            rem_d  = '0;
            done_d = 1'b0;
        end else if (fall && bus_idle) begin
            restart = 1'b1;
            ph_d    = PH_SYNC;
            done_d  = 1'b0;
        end else begin
            unique case (ph_q)
                PH_SEG1: begin
                    if (fall && !done_q) begin
                        step   = (err1 < sjw) ? err1 : sjw;
                        done_d = 1'b1;
                    end
                    adj = rem_q + step;
                    if (tick) begin
                        if (adj == 1) begin
                            sample_point = 1'b1;
                            ph_d         = PH_SEG2;
                            rem_d        = tseg2;
                        end else begin
                            rem_d = adj - 1'b1;
                        end
                    end else begin
                        rem_d = adj;
                    end
                end
                PH_SEG2: begin
                    if (fall && !done_q) begin
                        step   = (rem_q < sjw) ? rem_q : sjw;
                        done_d = 1'b1;
                    end
                    adj = rem_q - step;
                    if (adj == 0) begin
                        restart = 1'b1;
                        ph_d    = PH_SYNC;
                        done_d  = 1'b0;
                    end else if (tick) begin
                        if (adj == 1) begin
                            ph_d   = PH_SYNC;
                            done_d = 1'b0;
                        end
                        rem_d = adj - 1'b1;
                    end else begin
                        rem_d = adj;
                    end
                end
                default: begin
                    if (tick) begin
                        ph_d   = PH_SEG1;
                        rem_d  = tseg1;
                        done_d = 1'b0;
                    end
                end
            endcase
        end
    end

    // Register the phase, the quanta left and the resync-used flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_SYNC;
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            rem_q  <= rem_d;
            done_q <= done_d;
        end
    end

    // Keep the previous line level for edge detection (recessive at reset).
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx_in;
    end

endmodule

// File: rtl/can_bt_sampler.sv
// Bit sampler: captures the line at each quantum tick and, at the sample
// point, returns either the current value or the 2-of-3 majority.
// Assumes the caller decides whether triple mode is legal.
module can_bt_sampler #(
    parameter bit TRIPLE_SUPPORT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sample_point,
    input  logic triple_on,
    input  logic rx_in,
    output logic sample_stb,
    output logic sample_bit
);

    logic voted;

    generate
        if (TRIPLE_SUPPORT) begin : g_triple
            logic [1:0] hist_q;
            // Keep the line values from the two most recent quantum ticks.
            always_ff @(posedge clk) begin
                if (!rst_n)    hist_q <= 2'b11;
                else if (tick) hist_q <= {hist_q[0], rx_in};
            end
            assign voted = triple_on
                         ? ((hist_q[1] & hist_q[0]) | (hist_q[1] & rx_in) | (hist_q[0] & rx_in))
                         : rx_in;
        end else begin : g_single
            logic unused_triple;
            assign unused_triple = triple_on ^ tick;
            assign voted = rx_in;
        end
    endgenerate

    // Present the strobe and the bit one clock after the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            sample_bit <= 1'b1;
        end else begin
            sample_stb <= sample_point;
            if (sample_point) sample_bit <= voted;
        end
    end

endmodule

// File: rtl/can_bit_timing.sv
// Top: CAN bit timing sample generator. Ties configuration, prescaler,
// segment sequencer and sampler together. Timing is parked while a
// configuration change is requested or acknowledged.
module can_bit_timing
    import can_bt_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_WORD     = '0,
    parameter bit                TRIPLE_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    input  logic              rx_in,
    input  logic              bus_idle,
    output logic              tq_tick,
    output logic              sample_stb,
    output logic              sample_bit
);

    bt_cfg_t cfg_q;
    logic    hold, restart, sample_point, triple_on;

    assign hold      = cfg_req | cfg_ack;
    assign triple_on = cfg_q.triple && (cfg_q.brp_m1 >= BRP_W'(TRIPLE_MIN_BRP_M1));

    can_bt_cfg #(.RESET_WORD(RESET_WORD)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_q(cfg_q)
    );

    can_bt_prescaler u_presc (
        .clk(clk), .rst_n(rst_n), .hold(hold), .restart(restart),
        .brp_m1(cfg_q.brp_m1), .tick(tq_tick)
    );

    can_bt_segment u_seg (
        .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tq_tick), .rx_in(rx_in),
        .bus_idle(bus_idle), .cfg(cfg_q), .restart(restart),
        .sample_point(sample_point)
    );

    can_bt_sampler #(.TRIPLE_SUPPORT(TRIPLE_SUPPORT)) u_smp (
        .clk(clk), .rst_n(rst_n), .tick(tq_tick), .sample_point(sample_point),
        .triple_on(triple_on), .rx_in(rx_in), .sample_stb(sample_stb),
        .sample_bit(sample_bit)
    );

endmodule

// File: rtl/can_bit_timing_chk.sv
// Checker for can_bit_timing: handshake, parking and strobe relations.
module can_bit_timing_chk
    import can_bt_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    cfg_req,
    input logic    cfg_wr,
    input logic    cfg_ack,
    input logic    tq_tick,
    input logic    sample_stb,
    input bt_cfg_t cfg_q
);

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg_ack == $past(cfg_req))); // R1

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_req && cfg_ack) |=> $stable(cfg_q)); // R2

    AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |-> (!tq_tick && !sample_stb)); // R3

    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(tq_tick)); // R5

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R5

endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
    .cfg_ack(cfg_ack), .tq_tick(tq_tick), .sample_stb(sample_stb),
    .cfg_q(cfg_q)
);

// File: tb/can_bit_timing_tb.sv
// Directed bench for can_bit_timing: one task per scenario.
module can_bit_timing_tb_top;

    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ack;
    logic        rx_in = 1'b1;
    logic        bus_idle = 1'b0;
    logic        tq_tick, sample_stb, sample_bit;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_timing dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .rx_in(rx_in),
        .bus_idle(bus_idle), .tq_tick(tq_tick), .sample_stb(sample_stb),
        .sample_bit(sample_bit)
    );

    // Record one check and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load a word through the change window; checks the acknowledge (R1).
    task automatic program_word(input logic [31:0] w);
        @(negedge clk); cfg_req = 1'b1;
        @(negedge clk); chk("R1 ack raised", cfg_ack, 1);
        cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0; cfg_req = 1'b0;
        @(negedge clk); chk("R1 ack dropped", cfg_ack, 0);
    endtask

    // Clocks between two successive quantum ticks.
    task automatic tick_period(output int p);
        int guard = 0;
        p = 0;
        do begin @(negedge clk); guard++; end while (!tq_tick && guard < 1000);
        do begin @(negedge clk); p++; end while (!tq_tick && p < 1000);
    endtask

    // Clocks between two successive sample strobes.
    task automatic stb_period(output int p);
        int guard = 0;
        p = 0;
        do begin @(negedge clk); guard++; end while (!sample_stb && guard < 5000);
        do begin @(negedge clk); p++; end while (!sample_stb && p < 5000);
    endtask

    // Hard sync, then optional soft edges; returns count to the nth strobe.
    // low1/low2: drive low after rising edge count low+1 (0 = none);
    // hi_at: drive high after that count.
    task automatic sync_watch(input int low1, input int low2, input int hi_at,
                              input int nth, output int n, output int bitv);
        int seen = 0;
        rx_in = 1'b1; bus_idle = 1'b1;
        repeat (3) @(negedge clk);
        rx_in = 1'b0;
        n = 0; bitv = -1;
        while (n < 2000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (sample_stb) begin
                seen++;
                if (seen == nth) begin bitv = int'(sample_bit); break; end
            end
            if (n == 1) bus_idle = 1'b0;
            if (n == hi_at) rx_in = 1'b1;
            if (low1 != 0 && n == low1 + 1) rx_in = 1'b0;
            if (low2 != 0 && n == low1 + 2) rx_in = 1'b1;
            if (low2 != 0 && n == low2 + 1) rx_in = 1'b0;
        end
        rx_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1 ack after reset", cfg_ack, 0);
        chk("R3 no strobe after reset", sample_stb, 0);
    endtask

    // Prescaler, bit time, write gating and parking.
    task automatic test_config();
        int p, cnt;
        program_word(32'h0002_001A);          // BRP 3, TSEG1 4, TSEG2 3
        tick_period(p); chk("R4 tick period", p, 3);
        stb_period(p);  chk("R5 bit period", p, 24);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'h0;
        @(negedge clk); cfg_wr = 1'b0;
        stb_period(p);  chk("R2 write without request ignored", p, 24);
        @(negedge clk); cfg_req = 1'b1; cfg_wr = 1'b1; cfg_wdata = 32'h0;
        @(negedge clk); cfg_wr = 1'b0; cfg_req = 1'b0;
        @(negedge clk);
        stb_period(p);  chk("R2 write before ack ignored", p, 24);
        @(negedge clk); cfg_req = 1'b1;
        cnt = 0;
        repeat (40) begin @(negedge clk); if (tq_tick || sample_stb) cnt++; end
        cfg_req = 1'b0;
        chk("R3 parked while acknowledged", cnt, 0);
        @(negedge clk);
        program_word(32'h0001_0009);          // BRP 2, TSEG1 2, TSEG2 2
        stb_period(p);  chk("R5 bit period second word", p, 10);
    endtask

    task automatic test_hard_sync();
        int n, b;
        program_word(32'h0002_001A);
        sync_watch(0, 0, 0, 1, n, b);
        chk("R6 hard sync to sample", n, 16);
    endtask

    // Soft resynchronisation with BRP 1, TSEG1 8, TSEG2 4, SJW 2.
    task automatic test_resync();
        int n, b;
        program_word(32'h0000_013B);
        sync_watch(0, 0, 0, 1, n, b);
        chk("R6 hard sync BRP 1", n, 10);
        sync_watch(1, 0, 1, 1, n, b);
        chk("R7 seg1 edge error 1", n, 11);
        sync_watch(5, 0, 1, 1, n, b);
        chk("R7 seg1 edge clamped by SJW", n, 12);
        sync_watch(2, 5, 1, 1, n, b);
        chk("R9 second edge ignored", n, 12);
        sync_watch(9, 0, 1, 2, n, b);
        chk("R8 seg2 edge shortened by SJW", n, 21);
        sync_watch(11, 0, 1, 2, n, b);
        chk("R8 seg2 edge starts next bit", n, 22);
        sync_watch(0, 0, 1, 2, n, b);
        chk("R5 undisturbed second sample", n, 23);
    endtask

    // Majority voting and its enable rule.
    task automatic test_sampling();
        int n, b;
        program_word(32'h0004_0099);          // BRP 5, triple on
        sync_watch(0, 0, 25, 1, n, b);
        chk("R10 triple sample time", n, 26);
        chk("R10 majority outvotes last sample", b, 0);
        program_word(32'h0004_0019);          // BRP 5, triple off
        sync_watch(0, 0, 25, 1, n, b);
        chk("R11 single sample value", b, 1);
        program_word(32'h0003_0099);          // BRP 4, triple requested
        sync_watch(0, 0, 20, 1, n, b);
        chk("R11 BRP 4 sample time", n, 21);
        chk("R11 triple refused at BRP 4", b, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_config();
        test_hard_sync();
        test_resync();
        test_sampling();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule